// File: doc/BRIEF.md
# Selective Frame Capture and Replay Controller

This block sits between an 8-bit streaming pixel source and a memory that holds one frame. Three mode inputs decide which incoming frames are written into that memory: none, one frame only, or every other frame. Every accepted live pixel also leaves the block one cycle later on a live output. When replay is enabled and a complete frame is held, the block reads the stored pixel at the same position as each incoming pixel. The stored pixel and the live pixel then leave the block in the same cycle, each with its own valid strobe.

Frames are delimited by a start-of-frame marker on the first pixel. The frame size is set by the `IMG_W` and `IMG_H` parameters. The memory is synchronous, has a single port and a read latency of one cycle, which is why the live path carries one register stage. A status output reports that a complete frame has been written. It is held until the mode inputs change or reset is applied. The block is intended for a 15 MHz pixel clock.

Top module: `cam_fbuf_ctrl`

## Requirements
- R1: With `cfg_save` low, no pixel is ever written to memory (`mem_we` stays low), whatever `cfg_once` and `cfg_alt` are. The combinations save=1, once=0, alt=0 and save=1, once=1, alt=1 behave in the same way.
- R2: With save=1, once=0, alt=1, the 1st, 3rd, 5th and later odd frames after entering the mode are written to memory. The even frames are not written.
- R3: With save=1, once=1, alt=0, exactly one complete frame is written. Later frames are not written until the mode inputs change to another value and back.
- R4: A pixel is accepted only if it carries the start-of-frame marker, or if it follows one within the same frame. The start-of-frame pixel has address 0. Later pixels take addresses in increasing order up to `IMG_W*IMG_H-1`. Pixels before the first marker, or beyond the last address, are ignored: no write, no read, no live valid.
- R5: `frame_stored` rises in the cycle after the write of address `IMG_W*IMG_H-1` in a captured frame. It stays high until the decoded mode changes or reset is applied. A frame cut short by a new start-of-frame marker does not raise it.
- R6: Each accepted pixel appears on `live_px` with `live_vld` high exactly one cycle after it is presented.
- R7: When `replay_en` is high, `frame_stored` is high and the pixel is not being written, the block reads the memory (`mem_re`) at the live pixel's address. The stored pixel appears on `stored_px` with `stored_vld` in the same cycle as the live copy of that pixel.
- R8: A write and a read never take place in the same cycle. When a pixel is written, no read is made for that pixel and `stored_vld` stays low in its output cycle.
- R9: While reset is applied and directly after it, `mem_we`, `mem_re`, `live_vld`, `stored_vld`, `stored_px` and `frame_stored` are low.
- R10: In alternate-frame mode, `frame_stored` stays high through the frames that are not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_save | input | 1 | Frame saving enable |
| cfg_once | input | 1 | Single-frame capture select |
| cfg_alt | input | 1 | Alternate-frame capture select |
| replay_en | input | 1 | Enable output of the stored frame |
| px_in | input | 8 | Live pixel value |
| px_vld | input | 1 | Live pixel valid |
| px_sof | input | 1 | Marks the first pixel of a frame |
| mem_addr | output | $clog2(IMG_W*IMG_H) | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read enable |
| mem_rdata | input | 8 | Memory read data, one cycle after `mem_re` |
| live_px | output | 8 | Delayed live pixel |
| live_vld | output | 1 | Live pixel valid |
| stored_px | output | 8 | Stored pixel at the same position |
| stored_vld | output | 1 | Stored pixel valid |
| frame_stored | output | 1 | A complete frame is held in memory |

## Verification
Capture and replay can both ask for the single memory port in the same pixel cycle. This happens in alternate-frame mode with replay enabled, when a held frame exists and an odd frame arrives that must overwrite it. The bench drives exactly that sequence. It then judges every pixel of the overwriting frame: the write must go through, no read may be made, and the stored valid must stay low while the live copy still appears. On the frames that are not written, the stored data must equal the pixel values of the last captured frame, position by position.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

    localparam int PIX_W = 8;

    typedef enum logic [1:0] {
        FB_OFF     = 2'd0,
        FB_ONESHOT = 2'd1,
        FB_ALT     = 2'd2
    } fb_mode_e;

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] data;
    } pix_beat_t;

    // Undefined combinations fall back to buffering disabled.
    function automatic fb_mode_e fb_decode(input logic save, input logic once, input logic alt);
        fb_mode_e m;
        m = FB_OFF;
        if (save && once && !alt) m = FB_ONESHOT;
        if (save && !once && alt) m = FB_ALT;
        return m;
    endfunction

endpackage

// File: rtl/cfb_addr_gen.sv
module cfb_addr_gen #(
    parameter int NPIX = 12,
    localparam int AW = (NPIX > 1) ? $clog2(NPIX) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          px_vld,
    input  logic          px_sof,
    output logic          pix_acc,
    output logic          pix_first,
    output logic          pix_last,
    output logic [AW-1:0] pix_addr
);

    logic [AW-1:0] pos_q;
    logic          in_frame_q;

    assign pix_first = px_vld && px_sof;
    assign pix_acc   = px_vld && (px_sof || in_frame_q);
    assign pix_addr  = px_sof ? '0 : pos_q;
    assign pix_last  = pix_acc && (pix_addr == AW'(NPIX - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q      <= '0;
            in_frame_q <= 1'b0;
        end else if (pix_acc) begin
            if (pix_last) begin
                in_frame_q <= 1'b0;
                pos_q      <= '0;
            end else begin
                in_frame_q <= 1'b1;
                pos_q      <= pix_addr + 1'b1;
            end
        end
    end

    initial begin
        a_r4_min_frame: assert (NPIX >= 2);
    end

    a_r4_first_at_zero: assert property (@(posedge clk) disable iff (rst)
        pix_first |-> (pix_addr == '0));
    a_r4_addr_in_range: assert property (@(posedge clk) disable iff (rst)
        pix_acc |-> (pix_addr < AW'(NPIX)));
    a_r4_addr_steps: assert property (@(posedge clk) disable iff (rst)
        (pix_acc && !pix_last) ##1 (pix_acc && !pix_first) |-> (pix_addr == $past(pix_addr) + 1'b1));

endmodule

// File: rtl/cfb_capture_ctl.sv
module cfb_capture_ctl
    import cfb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  fb_mode_e mode,
    input  logic     pix_acc,
    input  logic     pix_first,
    input  logic     pix_last,
    output logic     wr_now,
    output logic     stored
);

    fb_mode_e mode_q;
    logic     mode_chg;
    logic     capt_q;
    logic     done_q;
    logic     phase_q;
    logic     stored_q;
    logic     want;
    logic     start;

    assign mode_chg = (mode != mode_q);
    assign want     = ((mode == FB_ONESHOT) && !done_q) || ((mode == FB_ALT) && !phase_q);
    assign start    = pix_first && want;
    assign wr_now   = pix_acc && !mode_chg && (pix_first ? start : capt_q);
    assign stored   = stored_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= FB_OFF;
            capt_q   <= 1'b0;
            done_q   <= 1'b0;
            phase_q  <= 1'b0;
            stored_q <= 1'b0;
        end else begin
            mode_q <= mode;
            if (mode_chg) begin
                capt_q   <= 1'b0;
                done_q   <= 1'b0;
                phase_q  <= 1'b0;
                stored_q <= 1'b0;
            end else begin
                if (pix_first) begin
                    capt_q <= start && !pix_last;
                    if (mode == FB_ALT) phase_q <= !phase_q;
                end else if (pix_last) begin
                    capt_q <= 1'b0;
                end
                if (wr_now && pix_last) begin
                    stored_q <= 1'b1;
                    if (mode == FB_ONESHOT) done_q <= 1'b1;
                end
            end
        end
    end

    a_r1_off_no_write: assert property (@(posedge clk) disable iff (rst)
        (mode == FB_OFF) |-> !wr_now);
    a_r5_flag_held: assert property (@(posedge clk) disable iff (rst)
        (stored_q && (mode == $past(mode)) && (mode == mode_q)) |=> stored_q);
    a_r3_single_capture: assert property (@(posedge clk) disable iff (rst)
        (done_q && (mode == FB_ONESHOT) && !mode_chg) |-> !wr_now);

endmodule

// File: rtl/cfb_out_align.sv
module cfb_out_align
    import cfb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_acc,
    input  logic [PIX_W-1:0] px_in,
    input  logic             rd_now,
    input  logic [PIX_W-1:0] mem_rdata,
    output logic [PIX_W-1:0] live_px,
    output logic             live_vld,
    output logic [PIX_W-1:0] stored_px,
    output logic             stored_vld
);

    pix_beat_t live_q;
    logic      rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            rd_q   <= 1'b0;
        end else begin
            live_q.vld  <= pix_acc;
            live_q.data <= pix_acc ? px_in : live_q.data;
            rd_q        <= rd_now;
        end
    end

    assign live_px    = live_q.data;
    assign live_vld   = live_q.vld;
    assign stored_vld = rd_q;
    assign stored_px  = rd_q ? mem_rdata : '0;

    a_r6_live_follows: assert property (@(posedge clk) disable iff (rst)
        pix_acc |=> live_vld);
    a_r7_stored_with_live: assert property (@(posedge clk) disable iff (rst)
        stored_vld |-> live_vld);

endmodule

// File: rtl/cam_fbuf_ctrl.sv
module cam_fbuf_ctrl
    import cfb_pkg::*;
#(
    parameter int IMG_W = 4,
    parameter int IMG_H = 3,
    localparam int NPIX = IMG_W * IMG_H,
    localparam int AW = (NPIX > 1) ? $clog2(NPIX) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_save,
    input  logic          cfg_once,
    input  logic          cfg_alt,
    input  logic          replay_en,
    input  logic [7:0]    px_in,
    input  logic          px_vld,
    input  logic          px_sof,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [7:0]    mem_wdata,
    output logic          mem_re,
    input  logic [7:0]    mem_rdata,
    output logic [7:0]    live_px,
    output logic          live_vld,
    output logic [7:0]    stored_px,
    output logic          stored_vld,
    output logic          frame_stored
);

    fb_mode_e      mode;
    logic          pix_acc;
    logic          pix_first;
    logic          pix_last;
    logic [AW-1:0] pix_addr;
    logic          wr_now;
    logic          stored;
    logic          rd_now;

    assign mode = fb_decode(cfg_save, cfg_once, cfg_alt);

    cfb_addr_gen #(.NPIX(NPIX)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .px_vld    (px_vld),
        .px_sof    (px_sof),
        .pix_acc   (pix_acc),
        .pix_first (pix_first),
        .pix_last  (pix_last),
        .pix_addr  (pix_addr)
    );

    cfb_capture_ctl u_capt (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .pix_acc   (pix_acc),
        .pix_first (pix_first),
        .pix_last  (pix_last),
        .wr_now    (wr_now),
        .stored    (stored)
    );

    // Single port: a write owns the cycle, replay yields.
    assign rd_now = replay_en && stored && pix_acc && !wr_now;

    cfb_out_align u_out (
        .clk        (clk),
        .rst        (rst),
        .pix_acc    (pix_acc),
        .px_in      (px_in),
        .rd_now     (rd_now),
        .mem_rdata  (mem_rdata),
        .live_px    (live_px),
        .live_vld   (live_vld),
        .stored_px  (stored_px),
        .stored_vld (stored_vld)
    );

    assign mem_addr     = pix_addr;
    assign mem_we       = wr_now;
    assign mem_wdata    = px_in;
    assign mem_re       = rd_now;
    assign frame_stored = stored;

    a_r8_port_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));
    a_r7_read_returns: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> stored_vld);
    a_r8_write_no_stored: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !stored_vld);
    a_r4_ignored_no_access: assert property (@(posedge clk) disable iff (rst)
        !px_vld |-> !(mem_we || mem_re));

endmodule

// File: tb/tb_cam_fbuf_ctrl.sv
module tb_cam_fbuf_ctrl;

    localparam int W    = 4;
    localparam int H    = 3;
    localparam int NPIX = W * H;
    localparam int AW   = $clog2(NPIX);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_save = 1'b0, cfg_once = 1'b0, cfg_alt = 1'b0, replay_en = 1'b0;
    logic [7:0]    px_in = '0;
    logic          px_vld = 1'b0, px_sof = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_we, mem_re;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;
    logic [7:0]    live_px, stored_px;
    logic          live_vld, stored_vld, frame_stored;

    logic [7:0]    mem [NPIX];

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    cam_fbuf_ctrl #(.IMG_W(W), .IMG_H(H)) dut (
        .clk(clk), .rst(rst), .cfg_save(cfg_save), .cfg_once(cfg_once), .cfg_alt(cfg_alt),
        .replay_en(replay_en), .px_in(px_in), .px_vld(px_vld), .px_sof(px_sof),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .live_px(live_px), .live_vld(live_vld),
        .stored_px(stored_px), .stored_vld(stored_vld), .frame_stored(frame_stored)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    function automatic logic [7:0] pix(input int fid, input int i);
        return 8'((fid * 16 + i + 1) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_mode(input bit s, input bit o, input bit a);
        @(posedge clk); #1;
        cfg_save = s; cfg_once = o; cfg_alt = a;
        repeat (2) @(posedge clk);
    endtask

    // Sends n pixels of frame fid; wr/rd are the expected write and read behaviour,
    // sfid is the frame whose data the stored output must return.
    task automatic run_frame(input int n, input bit wr, input bit rd, input int fid,
                             input int sfid, input string req);
        for (int i = 0; i <= n; i++) begin
            @(posedge clk); #1;
            if (i < n) begin
                px_vld = 1'b1; px_sof = (i == 0); px_in = pix(fid, i);
            end else begin
                px_vld = 1'b0; px_sof = 1'b0;
            end
            @(negedge clk);
            if (i < n && i < NPIX) begin
                chk(mem_we == wr, {req, " write enable"}, int'(mem_we), int'(wr));
                chk(int'(mem_addr) == i, "R4 address order", int'(mem_addr), i);
                chk(mem_re == (rd && !wr), {"R8 ", req, " read enable"}, int'(mem_re), int'(rd && !wr));
                if (wr) chk(mem_wdata == pix(fid, i), "R4 write data", int'(mem_wdata), int'(pix(fid, i)));
            end else if (i < n) begin
                chk(!mem_we && !mem_re, "R4 beyond last address", int'(mem_we), 0);
            end
            if (i > 0) begin
                int j;
                j = i - 1;
                chk(live_vld == (j < NPIX), "R6 live valid", int'(live_vld), int'(j < NPIX));
                if (j < NPIX) chk(live_px == pix(fid, j), "R6 live pixel", int'(live_px), int'(pix(fid, j)));
                chk(stored_vld == (rd && !wr && j < NPIX), "R7 stored valid", int'(stored_vld),
                    int'(rd && !wr && j < NPIX));
                if (rd && !wr && j < NPIX)
                    chk(stored_px == pix(sfid, j), "R7 stored pixel same position", int'(stored_px),
                        int'(pix(sfid, j)));
            end
        end
        repeat (3) @(posedge clk);
    endtask

    task automatic chk_flag(input bit exp, input string req);
        @(negedge clk);
        chk(frame_stored == exp, req, int'(frame_stored), int'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk(!mem_we && !mem_re && !live_vld && !stored_vld && !frame_stored && stored_px == 0,
            "R9 outputs during reset", int'(frame_stored), 0);
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        chk(!mem_we && !mem_re && !live_vld && !stored_vld && !frame_stored,
            "R9 outputs after reset", int'(live_vld), 0);

        // R4: stray pixels before any start-of-frame are ignored
        replay_en = 1'b1;
        set_mode(1, 1, 0);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1; px_vld = 1'b1; px_sof = 1'b0; px_in = 8'hAA;
            @(negedge clk);
            chk(!mem_we && !mem_re, "R4 pre-frame no access", int'(mem_we), 0);
            if (i > 0) chk(!live_vld, "R4 pre-frame no live", int'(live_vld), 0);
        end
        @(posedge clk); #1; px_vld = 1'b0;
        set_mode(0, 0, 0);

        // R1: save low or undefined combinations never write
        set_mode(0, 1, 1); run_frame(NPIX, 0, 0, 1, 0, "R1 save low");
        set_mode(0, 1, 0); run_frame(NPIX, 0, 0, 2, 0, "R1 save low once");
        set_mode(1, 0, 0); run_frame(NPIX, 0, 0, 3, 0, "R1 undefined 100");
        set_mode(1, 1, 1); run_frame(NPIX, 0, 0, 4, 0, "R1 undefined 111");
        chk_flag(0, "R5 no flag without capture");

        // R3 one-shot capture
        replay_en = 1'b0;
        set_mode(1, 1, 0);
        run_frame(NPIX, 1, 0, 5, 0, "R3 one-shot first frame");
        chk_flag(1, "R5 flag after full frame");
        run_frame(NPIX, 0, 0, 6, 0, "R3 one-shot second frame");
        chk_flag(1, "R5 flag held");
        replay_en = 1'b1;
        run_frame(NPIX + 3, 0, 1, 7, 5, "R7 replay of one-shot frame");

        // R5 re-arm clears flag; cut-short frame does not set it
        set_mode(0, 0, 0);
        chk_flag(0, "R5 flag cleared on mode change");
        set_mode(1, 1, 0);
        run_frame(5, 1, 0, 8, 0, "R5 cut-short frame");
        chk_flag(0, "R5 short frame leaves flag low");
        run_frame(NPIX, 1, 0, 9, 0, "R3 re-armed capture");
        chk_flag(1, "R5 flag after re-armed capture");
        run_frame(NPIX, 0, 1, 10, 9, "R7 replay after re-arm");

        // R2 / R8 / R10 alternate frames with replay
        set_mode(1, 0, 1);
        chk_flag(0, "R5 flag cleared entering alternate mode");
        run_frame(NPIX, 1, 0, 11, 0, "R2 alt frame 1");
        chk_flag(1, "R5 flag after alt capture");
        run_frame(NPIX, 0, 1, 12, 11, "R2 alt frame 2");
        chk_flag(1, "R10 flag held over skipped frame");
        run_frame(NPIX, 1, 1, 13, 0, "R8 alt frame 3 collision");
        chk_flag(1, "R10 flag after overwrite");
        run_frame(NPIX, 0, 1, 14, 13, "R2 alt frame 4");
        run_frame(NPIX, 1, 1, 15, 0, "R2 alt frame 5");

        // R9 reset clears the flag
        @(posedge clk); #1; rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        chk_flag(0, "R9 flag cleared by reset");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule